// File: doc/BRIEF.md
# Card power sequencing controller

This controller brings the DC/DC converters of an add-in card up and down. It watches four kinds of status: the 3.3 V auxiliary supply together with a logic-ready indication, a flag that reports the 12 V main supply is out of range, the active-low reset from the host slot, and one power-good line per converter rail. From these it drives one enable per rail. A bleed output removes residual charge once every rail has been switched off, and a latched fault flag reports a rail that misbehaved.

All status inputs are asynchronous. Each one passes through a two-stage synchroniser before the state machine acts on it. The states are off, ramp-up, on, ramp-down, bleed and fault. In the default build all rails switch together. With `SEQUENCED` set to 1, the rails come up one at a time in index order and go down in reverse order. Every wait is counted in clock cycles and bounded by a parameter.

Top module: `card_pwr_seq`

## Requirements
- R1: Every status input passes through two synchronising flops. A change at an input reaches the outputs on the third rising clock edge after the change, and no sooner.
- R2: Power-up begins only while the auxiliary supply is good, the main-supply fail flag is low and the slot reset is deasserted. While the controller is ramping up or on, losing any of these three conditions starts a power-down.
- R3: A main-supply fail seen while the card is on switches every rail off through the normal power-down. This does not set the fault flag.
- R4: Asserting the slot reset powers the card down. Deasserting it again, with good supplies, powers the card back up.
- R5: With `SEQUENCED`=0, `rail_en_o` is always all-zero or all-one. The rails switch on together. On power-down they switch off together, and the controller then waits until every power-good is low, or until `PG_TIMEOUT` cycles have passed.
- R6: With `SEQUENCED`=1, `rail_en_o` is always a run of ones starting at bit 0. Rail k+1 is enabled only once the power-good of rails 0..k is high. On power-down the highest enabled rail is switched off first. Each following step waits until no disabled rail still reports power-good, or until `PG_TIMEOUT` cycles have passed.
- R7: The on state is reached only when every power-good is high. If a rail's power-good is still low after `PG_TIMEOUT` cycles, all enables drop in the same cycle, the bleed starts and `fault_o` is set.
- R8: In the on state, any power-good going low causes the same immediate shutdown, bleed and fault.
- R9: Once set, `fault_o` stays high, and no new power-up begins, until the synchronised slot reset is seen asserted. The flag then clears.
- R10: `bleed_o` is high for exactly `DISCH_CYCLES` cycles per power-down. It is never high while any enable is high. Afterwards the controller returns to off, or to fault when the flag is set.
- R11: A synchronous reset (`rst` high) clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_ok_i | input | 1 | 3.3 V present and logic started (asynchronous) |
| main_fail_i | input | 1 | 12 V supply out of range (asynchronous) |
| slot_rst_n_i | input | 1 | Active-low slot reset from the host (asynchronous) |
| rail_pg_i | input | N_RAILS | Power-good per converter rail (asynchronous) |
| rail_en_o | output | N_RAILS | Enable per converter rail |
| bleed_o | output | 1 | Residual-voltage discharge control |
| fault_o | output | 1 | Latched rail fault |

## Verification
The bench builds two instances, each with three rails, a power-good timeout of 12 cycles and a bleed length of 6 cycles. One instance runs the default simultaneous mode and the other the sequenced mode. Both share the supply and reset stimulus, and each gets its own rail model with a programmable delay. With these short windows the bench can reach, in a few hundred cycles, the timeout fault, the ramp-down timeout on rails held high, a power-good dropout, and the rule that the fault persists until reset. It can also compare rail ordering in both modes against the reference model on every clock.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PS_OFF       = 3'd0,
    PS_RAMP_UP   = 3'd1,
    PS_ON        = 3'd2,
    PS_RAMP_DOWN = 3'd3,
    PS_BLEED     = 3'd4,
    PS_FAULT     = 3'd5
  } pwr_state_e;

endpackage

// File: rtl/pwrseq_sync.sv
// Multi-stage synchroniser bank; STAGES must be at least 2.
module pwrseq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pwrseq_railmask.sv
// Combinational helper: next enable masks and rail status summaries.
module pwrseq_railmask #(
  parameter int N_RAILS   = 4,
  parameter bit SEQUENCED = 1'b0
) (
  input  logic [N_RAILS-1:0] en_i,
  input  logic [N_RAILS-1:0] pg_i,
  output logic [N_RAILS-1:0] first_o,
  output logic [N_RAILS-1:0] up_o,
  output logic [N_RAILS-1:0] down_o,
  output logic               en_good_o,
  output logic               all_en_o,
  output logic               all_pg_o,
  output logic               off_settled_o
);

  localparam logic [N_RAILS-1:0] ALL_ONES = {N_RAILS{1'b1}};

  generate
    if (SEQUENCED) begin : g_seq
      // enables form a prefix of ones; grow at bit 0 side, shrink from top
      assign first_o = N_RAILS'(1);
      assign up_o    = {en_i[N_RAILS-2:0], 1'b1};
      assign down_o  = {1'b0, en_i[N_RAILS-1:1]};
    end else begin : g_all
      assign first_o = ALL_ONES;
      assign up_o    = ALL_ONES;
      assign down_o  = '0;
    end
  endgenerate

  assign en_good_o     = (pg_i & en_i) == en_i;
  assign all_en_o      = en_i == ALL_ONES;
  assign all_pg_o      = pg_i == ALL_ONES;
  assign off_settled_o = (pg_i & ~en_i) == '0;

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int N_RAILS      = 4,
  parameter int PG_TIMEOUT   = 1000,
  parameter int DISCH_CYCLES = 200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ok_i,
  input  logic               fail_i,
  input  logic               run_i,
  input  logic [N_RAILS-1:0] first_i,
  input  logic [N_RAILS-1:0] up_i,
  input  logic [N_RAILS-1:0] down_i,
  input  logic               en_good_i,
  input  logic               all_en_i,
  input  logic               all_pg_i,
  input  logic               off_settled_i,
  output logic [N_RAILS-1:0] en_o,
  output logic               bleed_o,
  output logic               fault_o
);

  localparam int TMAX  = (PG_TIMEOUT > DISCH_CYCLES) ? PG_TIMEOUT : DISCH_CYCLES;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] PG_LAST = TMR_W'(PG_TIMEOUT - 1);
  localparam logic [TMR_W-1:0] BL_LAST = TMR_W'(DISCH_CYCLES - 1);

  pwr_state_e       st;
  logic [TMR_W-1:0] tmr;
  logic             stop;

  assign stop = !run_i || fail_i || !ok_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PS_OFF;
      tmr     <= '0;
      en_o    <= '0;
      bleed_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      unique case (st)
        PS_OFF: begin
          if (ok_i && !fail_i && run_i) begin
            st   <= PS_RAMP_UP;
            en_o <= first_i;
            tmr  <= '0;
          end
        end
        PS_RAMP_UP: begin
          if (stop) begin
            st  <= PS_RAMP_DOWN;
            tmr <= '0;
          end else if (en_good_i) begin
            tmr <= '0;
            if (all_en_i) st <= PS_ON;
            else          en_o <= up_i;
          end else if (tmr == PG_LAST) begin
            st      <= PS_BLEED;
            en_o    <= '0;
            bleed_o <= 1'b1;
            fault_o <= 1'b1;
            tmr     <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        PS_ON: begin
          if (stop) begin
            st  <= PS_RAMP_DOWN;
            tmr <= '0;
          end else if (!all_pg_i) begin
            st      <= PS_BLEED;
            en_o    <= '0;
            bleed_o <= 1'b1;
            fault_o <= 1'b1;
            tmr     <= '0;
          end
        end
        PS_RAMP_DOWN: begin
          if (off_settled_i || tmr == PG_LAST) begin
            tmr <= '0;
            if (en_o == '0) begin
              st      <= PS_BLEED;
              bleed_o <= 1'b1;
            end else begin
              en_o <= down_i;
            end
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        PS_BLEED: begin
          if (tmr == BL_LAST) begin
            tmr     <= '0;
            bleed_o <= 1'b0;
            st      <= fault_o ? PS_FAULT : PS_OFF;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        PS_FAULT: begin
          if (!run_i) begin
            fault_o <= 1'b0;
            st      <= PS_OFF;
          end
        end
        default: st <= PS_OFF;
      endcase
    end
  end

endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq #(
  parameter int N_RAILS      = 4,
  parameter int PG_TIMEOUT   = 1000,
  parameter int DISCH_CYCLES = 200,
  parameter bit SEQUENCED    = 1'b0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               aux_ok_i,
  input  logic               main_fail_i,
  input  logic               slot_rst_n_i,
  input  logic [N_RAILS-1:0] rail_pg_i,
  output logic [N_RAILS-1:0] rail_en_o,
  output logic               bleed_o,
  output logic               fault_o
);

  localparam int SW = N_RAILS + 3;

  logic [SW-1:0]      sync_q;
  logic               ok_s, fail_s, run_s;
  logic [N_RAILS-1:0] pg_s;
  logic [N_RAILS-1:0] first_m, up_m, down_m;
  logic               en_good, all_en, all_pg, off_settled;

  pwrseq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({rail_pg_i, aux_ok_i, main_fail_i, slot_rst_n_i}),
    .q_o (sync_q)
  );

  assign {pg_s, ok_s, fail_s, run_s} = sync_q;

  pwrseq_railmask #(.N_RAILS(N_RAILS), .SEQUENCED(SEQUENCED)) u_mask (
    .en_i          (rail_en_o),
    .pg_i          (pg_s),
    .first_o       (first_m),
    .up_o          (up_m),
    .down_o        (down_m),
    .en_good_o     (en_good),
    .all_en_o      (all_en),
    .all_pg_o      (all_pg),
    .off_settled_o (off_settled)
  );

  pwrseq_fsm #(
    .N_RAILS      (N_RAILS),
    .PG_TIMEOUT   (PG_TIMEOUT),
    .DISCH_CYCLES (DISCH_CYCLES)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .ok_i          (ok_s),
    .fail_i        (fail_s),
    .run_i         (run_s),
    .first_i       (first_m),
    .up_i          (up_m),
    .down_i        (down_m),
    .en_good_i     (en_good),
    .all_en_i      (all_en),
    .all_pg_i      (all_pg),
    .off_settled_i (off_settled),
    .en_o          (rail_en_o),
    .bleed_o       (bleed_o),
    .fault_o       (fault_o)
  );

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
  parameter int N_RAILS      = 4,
  parameter int DISCH_CYCLES = 200,
  parameter bit SEQUENCED    = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic [N_RAILS-1:0] rail_en,
  input logic               bleed,
  input logic               fault,
  input logic               ok_s,
  input logic               fail_s,
  input logic               run_s
);

  localparam int CW = $clog2(DISCH_CYCLES + 2);

  logic [CW-1:0] bl_cnt;

  always_ff @(posedge clk) begin
    if (rst)        bl_cnt <= '0;
    else if (bleed) bl_cnt <= bl_cnt + CW'(1);
    else            bl_cnt <= '0;
  end

  p_start_gated_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rail_en) == '0 && rail_en != '0) |-> $past(ok_s && !fail_s && run_s));

  p_all_together_r5: assert property (@(posedge clk) disable iff (rst)
    SEQUENCED || rail_en == '0 || (&rail_en));

  p_prefix_order_r6: assert property (@(posedge clk) disable iff (rst)
    !SEQUENCED || ((rail_en & (rail_en + N_RAILS'(1))) == '0));

  p_fault_shutdown_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> (rail_en == '0 && bleed));

  p_fault_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(fault) |-> !$past(run_s));

  p_bleed_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    bleed |-> rail_en == '0);

  p_bleed_length_r10: assert property (@(posedge clk) disable iff (rst)
    bleed |-> bl_cnt < CW'(DISCH_CYCLES));

endmodule

bind card_pwr_seq pwrseq_checker #(
  .N_RAILS      (N_RAILS),
  .DISCH_CYCLES (DISCH_CYCLES),
  .SEQUENCED    (SEQUENCED)
) u_pwrseq_checker (
  .clk     (clk),
  .rst     (rst),
  .rail_en (rail_en_o),
  .bleed   (bleed_o),
  .fault   (fault_o),
  .ok_s    (ok_s),
  .fail_s  (fail_s),
  .run_s   (run_s)
);

// File: tb/card_pwr_seq_bench.sv
`timescale 1ns/1ps
module card_pwr_seq_bench;

  localparam int NR  = 3;
  localparam int TO  = 12;
  localparam int DIS = 6;
  localparam int ALL = 7;
  localparam int S_OFF = 0, S_UP = 1, S_ON = 2, S_DN = 3, S_BL = 4, S_FT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aux_ok = 1'b0, main_fail = 1'b0, slot_rst_n = 1'b0;
  logic [NR-1:0] pg0 = '0, pg1 = '0;
  logic [NR-1:0] en0, en1;
  logic bl0, bl1, ft0, ft1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // rail model knobs: stuck low, forced dropout, held high
  int stuck = 0, drop = 0, hold = 0;
  int pcnt [2][NR];

  // reference model state
  int mst [2], men [2], mbl [2], mft [2], mtmr [2];
  int s1ok [2], s2ok [2], s1f [2], s2f [2], s1r [2], s2r [2], s1pg [2], s2pg [2];
  int blen [2];

  always #2.5 clk = ~clk;

  card_pwr_seq #(.N_RAILS(NR), .PG_TIMEOUT(TO), .DISCH_CYCLES(DIS), .SEQUENCED(1'b0)) u_card_pwr_seq (
    .clk(clk), .rst(rst), .aux_ok_i(aux_ok), .main_fail_i(main_fail), .slot_rst_n_i(slot_rst_n),
    .rail_pg_i(pg0), .rail_en_o(en0), .bleed_o(bl0), .fault_o(ft0));

  card_pwr_seq #(.N_RAILS(NR), .PG_TIMEOUT(TO), .DISCH_CYCLES(DIS), .SEQUENCED(1'b1)) u_card_pwr_seq_ordered (
    .clk(clk), .rst(rst), .aux_ok_i(aux_ok), .main_fail_i(main_fail), .slot_rst_n_i(slot_rst_n),
    .rail_pg_i(pg1), .rail_en_o(en1), .bleed_o(bl1), .fault_o(ft1));

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int get_en(input int d);
    return (d == 0) ? int'(en0) : int'(en1);
  endfunction

  // behavioural reference: one call per rising edge
  task automatic model_step(input int d);
    int ok, fl, rn, pg, stop, first, up, down;
    if (rst) begin
      mst[d] = S_OFF; men[d] = 0; mbl[d] = 0; mft[d] = 0; mtmr[d] = 0;
      s1ok[d] = 0; s2ok[d] = 0; s1f[d] = 0; s2f[d] = 0;
      s1r[d] = 0; s2r[d] = 0; s1pg[d] = 0; s2pg[d] = 0;
      return;
    end
    ok = s2ok[d]; fl = s2f[d]; rn = s2r[d]; pg = s2pg[d];
    stop  = (!rn || fl || !ok) ? 1 : 0;
    first = (d == 1) ? 1 : ALL;
    up    = (d == 1) ? (((men[d] << 1) | 1) & ALL) : ALL;
    down  = (d == 1) ? (men[d] >> 1) : 0;
    case (mst[d])
      S_OFF: if (ok && !fl && rn) begin mst[d] = S_UP; men[d] = first; mtmr[d] = 0; end
      S_UP: begin
        if (stop) begin mst[d] = S_DN; mtmr[d] = 0; end
        else if ((pg & men[d]) == men[d]) begin
          mtmr[d] = 0;
          if (men[d] == ALL) mst[d] = S_ON; else men[d] = up;
        end else if (mtmr[d] == TO - 1) begin
          mst[d] = S_BL; men[d] = 0; mbl[d] = 1; mft[d] = 1; mtmr[d] = 0;
        end else mtmr[d]++;
      end
      S_ON: begin
        if (stop) begin mst[d] = S_DN; mtmr[d] = 0; end
        else if (pg != ALL) begin mst[d] = S_BL; men[d] = 0; mbl[d] = 1; mft[d] = 1; mtmr[d] = 0; end
      end
      S_DN: begin
        if (((pg & ~men[d] & ALL) == 0) || mtmr[d] == TO - 1) begin
          mtmr[d] = 0;
          if (men[d] == 0) begin mst[d] = S_BL; mbl[d] = 1; end
          else men[d] = down;
        end else mtmr[d]++;
      end
      S_BL: begin
        if (mtmr[d] == DIS - 1) begin
          mtmr[d] = 0; mbl[d] = 0; mst[d] = mft[d] ? S_FT : S_OFF;
        end else mtmr[d]++;
      end
      default: if (!rn) begin mft[d] = 0; mst[d] = S_OFF; end
    endcase
    s2ok[d] = s1ok[d]; s2f[d] = s1f[d]; s2r[d] = s1r[d]; s2pg[d] = s1pg[d];
    s1ok[d] = int'(aux_ok); s1f[d] = int'(main_fail); s1r[d] = int'(slot_rst_n);
    s1pg[d] = (d == 0) ? int'(pg0) : int'(pg1);
  endtask

  always @(posedge clk) begin
    model_step(0);
    model_step(1);
  end

  // per-clock comparison against the model, bleed pulse monitor, rail model
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      int e, b, f;
      e = get_en(d);
      b = (d == 0) ? int'(bl0) : int'(bl1);
      f = (d == 0) ? int'(ft0) : int'(ft1);
      chk((d == 0) ? "R5" : "R6", e, men[d], "rail enables vs model");
      chk("R10", b, mbl[d], "bleed vs model");
      chk("R9", f, mft[d], "fault vs model");
      if (b != 0) begin
        blen[d]++;
        if (e != 0) chk("R10", e, 0, "enables during bleed");
      end else if (blen[d] > 0) begin
        chk("R10", blen[d], DIS, "bleed pulse length");
        blen[d] = 0;
      end
      for (int r = 0; r < NR; r++) begin
        int on, v;
        on = (e >> r) & 1;
        if (on != 0) begin if (pcnt[d][r] < 3) pcnt[d][r]++; end
        else if (pcnt[d][r] > 0) pcnt[d][r]--;
        if (((hold >> r) & 1) != 0) v = 1;
        else if ((((stuck | drop) >> r) & 1) != 0) v = 0;
        else v = (on != 0) ? ((pcnt[d][r] == 3) ? 1 : 0) : ((pcnt[d][r] > 0) ? 1 : 0);
        if (d == 0) pg0[r] = v[0]; else pg1[r] = v[0];
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic both_en(input string req, input int exp, input string what);
    chk(req, int'(en0), exp, {what, " (simultaneous)"});
    chk(req, int'(en1), exp, {what, " (sequenced)"});
  endtask

  task automatic both_ft(input string req, input int exp, input string what);
    chk(req, int'(ft0), exp, {what, " (simultaneous)"});
    chk(req, int'(ft1), exp, {what, " (sequenced)"});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      blen[d] = 0;
      for (int r = 0; r < NR; r++) pcnt[d][r] = 0;
    end
    wait_n(5);
    rst = 1'b0;
    // R11: reset state
    both_en("R11", 0, "enables after reset");
    chk("R11", int'(bl0) + int'(bl1), 0, "bleed after reset");
    both_ft("R11", 0, "fault after reset");

    // R2: slot reset held -> nothing starts
    aux_ok = 1'b1;
    wait_n(10);
    both_en("R2", 0, "no start under slot reset");
    // R2: main fail blocks start
    main_fail = 1'b1; slot_rst_n = 1'b1;
    wait_n(20);
    both_en("R2", 0, "no start while main supply fails");

    // R1: three-edge latency from input to enable
    main_fail = 1'b0;
    wait_n(2);
    both_en("R1", 0, "enables two edges after release");
    wait_n(1);
    chk("R5", int'(en0), ALL, "all rails enabled together");
    chk("R6", int'(en1), 1, "only rail 0 enabled first");
    chk("R1", (en0 != 0) ? 1 : 0, 1, "enables on third edge");
    wait_n(60);
    both_en("R7", ALL, "on state with every rail");
    both_ft("R7", 0, "no fault in normal ramp");

    // R3: main supply fail while on
    main_fail = 1'b1;
    wait_n(40);
    both_en("R3", 0, "rails off after main fail");
    both_ft("R3", 0, "main fail is not a fault");
    main_fail = 1'b0;
    wait_n(60);
    both_en("R4", ALL, "restart after main fail clears");

    // R4: slot reset cycle
    slot_rst_n = 1'b0;
    wait_n(40);
    both_en("R4", 0, "rails off under slot reset");
    slot_rst_n = 1'b1;
    wait_n(60);
    both_en("R4", ALL, "rails on after slot reset release");

    // R8: power-good dropout in on state
    drop = 2;
    wait_n(30);
    both_ft("R8", 1, "fault after dropout");
    both_en("R8", 0, "rails off after dropout");
    wait_n(60);
    drop = 0;
    wait_n(20);
    both_ft("R9", 1, "fault held until slot reset");
    both_en("R9", 0, "no restart while faulted");
    slot_rst_n = 1'b0;
    wait_n(5);
    both_ft("R9", 0, "fault cleared by slot reset");
    slot_rst_n = 1'b1;
    wait_n(60);
    both_en("R9", ALL, "restart after fault clear");

    // R7: rail 2 never reports good -> timeout fault
    slot_rst_n = 1'b0;
    wait_n(40);
    stuck = 4;
    slot_rst_n = 1'b1;
    wait_n(80);
    both_ft("R7", 1, "timeout fault");
    both_en("R7", 0, "rails off after timeout");
    stuck = 0;
    slot_rst_n = 1'b0;
    wait_n(5);
    slot_rst_n = 1'b1;
    wait_n(60);
    both_en("R7", ALL, "normal ramp after timeout fault");

    // R6/R5: power-good held high -> ramp-down steps time out
    hold = ALL;
    slot_rst_n = 1'b0;
    wait_n(100);
    both_en("R6", 0, "ramp-down completes on timeout");
    chk("R10", int'(bl0) + int'(bl1), 0, "bleed finished");
    both_ft("R6", 0, "ramp-down timeout is not a fault");
    hold = 0;
    wait_n(20);

    // R2: loss of auxiliary supply while on
    slot_rst_n = 1'b1;
    wait_n(60);
    both_en("R2", ALL, "on before auxiliary loss");
    aux_ok = 1'b0;
    wait_n(40);
    both_en("R2", 0, "rails off after auxiliary loss");
    wait_n(5);
    finish_run();
  end

endmodule